// File: doc/BRIEF.md
# Banked Programmable Interrupt Controller

This block gathers peripheral interrupt sources into banks of 32 and gives each bank one summary request line toward the processor. Every source passes through a two-flop synchronizer. It is then conditioned by its own polarity bit and its own trigger-mode bit. The result feeds a per-bank pending register. Software reaches six word registers per bank over a plain 32-bit register port. Through them it can mask sources, force a source pending, acknowledge a source by writing ones, and choose how each source is detected.

A bank's request line is high whenever a bit is pending and enabled in the same position. Level-mode sources mirror their conditioned input. Edge-mode sources latch on the selected transition and hold until software acknowledges them. The register port has no handshake: every access is taken in the cycle it is presented, so there is no back-pressure. Read data appears one cycle after the read strobe and holds until the next read.

Top module: `bank_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every enable, pending and mode bit is 0, every polarity bit is 1, and all request lines are low.
- R2: Bank b occupies byte addresses 24*b to 24*b+23. The low two address bits are ignored. The word offsets are: pending 0x0, enable 0x4, force 0x8, acknowledge 0xC, polarity 0x10, mode 0x14. Addresses at or above 24*NUM_BANKS read as 0, and writes to them change nothing.
- R3: `irq_o[b]` is high exactly when some bit is set in both the pending and enable registers of bank b.
- R4: Clearing an enable bit masks that source from the request line, and its pending bit stays readable and unchanged.
- R5: In edge mode, writing 1 to an acknowledge bit clears that pending bit at the write edge. Bits written as 0 have no effect.
- R6: In level mode (mode bit 0), a pending bit equals the conditioned input from the previous cycle, so an acknowledge has no lasting effect while the input stays active.
- R7: Writing 1 to a force bit makes that pending bit 1 at the write edge, whatever the mode and input.
- R8: Polarity bit 1 selects active-high (rising edge in edge mode). Polarity bit 0 selects active-low (falling edge).
- R9: In edge mode (mode bit 1), a selected transition sets the pending bit. If a transition and an acknowledge of the same bit fall in the same cycle, the bit stays pending.
- R10: Read data appears on the cycle after the read strobe. Reads of the force and acknowledge offsets return 0.
- R11: A raw input change reaches the pending register at the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | NUM_BANKS*SRC_PER_BANK | Raw asynchronous source inputs; bank b uses bits 32*b to 32*b+31 |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | SRC_PER_BANK | Write data |
| bus_rdata_o | output | SRC_PER_BANK | Read data, one cycle after the strobe |
| irq_o | output | NUM_BANKS | Per-bank request lines |

## Verification
The risky overlap is a software acknowledge that lands in the same clock edge as a fresh edge event on the same source. A lost edge would leave a device waiting forever. The bench raises an edge-mode input and issues the acknowledge write after a delay that sweeps across the synchronizer latency, so one of the delays places the write exactly on the latching edge. Every cycle's request lines and every read are compared against a behavioural model in which the new event wins, so the pending bit must survive in that case and drop in the others.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Byte span of one bank's register window.
  localparam int BANK_SPAN = 24;

  // Word index inside a bank window (byte offset / 4).
  typedef enum logic [2:0] {
    RS_PEND  = 3'd0,
    RS_ENA   = 3'd1,
    RS_FORCE = 3'd2,
    RS_ACK   = 3'd3,
    RS_POL   = 3'd4,
    RS_MODE  = 3'd5
  } regsel_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int NB     = 4,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NB-1:0]     hit_o,
  output regsel_e           sel_o
);
  always_comb begin
    hit_o = '0;
    sel_o = RS_PEND;
    for (int b = 0; b < NB; b++) begin
      if (({1'b0, addr_i} >= (ADDR_W+1)'(b * BANK_SPAN)) &&
          ({1'b0, addr_i} <  (ADDR_W+1)'((b + 1) * BANK_SPAN))) begin
        hit_o[b] = 1'b1;
        sel_o    = regsel_e'(3'((addr_i - ADDR_W'(b * BANK_SPAN)) >> 2));
      end
    end
  end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_i,
  input  logic         wr_i,
  input  regsel_e      sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] ena_o,
  output logic [W-1:0] mode_o,
  output logic [W-1:0] cond_o,
  output logic [W-1:0] event_o,
  output logic [W-1:0] force_o,
  output logic [W-1:0] ack_o,
  output logic [W-1:0] rdval_o,
  output logic         irq_o
);
  logic [W-1:0] ena_q, pol_q, mode_q, pend_q, prev_q, pend_nxt;

  // Software strobes, valid only for the cycle of the write.
  assign force_o = (wr_i && sel_i == RS_FORCE) ? wdata_i : '0;
  assign ack_o   = (wr_i && sel_i == RS_ACK)   ? wdata_i : '0;

  // Polarity 1 passes the input, 0 inverts it.
  assign cond_o  = ~(sync_i ^ pol_q);
  assign event_o = cond_o & ~prev_q;

  // Force dominates; edge bits hold until acknowledged, level bits mirror.
  assign pend_nxt = force_o
                  | (mode_q & ((pend_q & ~ack_o) | event_o))
                  | (~mode_q & cond_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ena_q  <= '0;
      pol_q  <= '1;
      mode_q <= '0;
      pend_q <= '0;
      prev_q <= '0;
    end else begin
      pend_q <= pend_nxt;
      prev_q <= cond_o;
      if (wr_i && sel_i == RS_ENA)  ena_q  <= wdata_i;
      if (wr_i && sel_i == RS_POL)  pol_q  <= wdata_i;
      if (wr_i && sel_i == RS_MODE) mode_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (sel_i)
      RS_PEND: rdval_o = pend_q;
      RS_ENA:  rdval_o = ena_q;
      RS_POL:  rdval_o = pol_q;
      RS_MODE: rdval_o = mode_q;
      default: rdval_o = '0;
    endcase
  end

  assign pend_o = pend_q;
  assign ena_o  = ena_q;
  assign mode_o = mode_q;
  assign irq_o  = |(pend_q & ena_q);
endmodule

// File: rtl/bank_irq_ctrl.sv
module bank_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int SRC_PER_BANK = 32,
  parameter int ADDR_W       = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_BANKS*SRC_PER_BANK-1:0] src_i,
  input  logic                              bus_wr_i,
  input  logic                              bus_rd_i,
  input  logic [ADDR_W-1:0]                 bus_addr_i,
  input  logic [SRC_PER_BANK-1:0]           bus_wdata_i,
  output logic [SRC_PER_BANK-1:0]           bus_rdata_o,
  output logic [NUM_BANKS-1:0]              irq_o
);
  localparam int SRC_W = NUM_BANKS * SRC_PER_BANK;

  logic [SRC_W-1:0]     src_sync;
  logic [NUM_BANKS-1:0] hit;
  regsel_e              sel;

  logic [NUM_BANKS-1:0][SRC_PER_BANK-1:0] pend_w, ena_w, mode_w, cond_w;
  logic [NUM_BANKS-1:0][SRC_PER_BANK-1:0] event_w, force_w, ack_w, rdval_w;
  logic [SRC_PER_BANK-1:0]                rd_mux;
  logic                                   rd_zero;

  irqc_sync #(.W(SRC_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (src_i),
    .q_o   (src_sync)
  );

  irqc_decode #(.NB(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .addr_i (bus_addr_i),
    .hit_o  (hit),
    .sel_o  (sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irqc_bank #(.W(SRC_PER_BANK)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_i  (src_sync[b*SRC_PER_BANK +: SRC_PER_BANK]),
      .wr_i    (bus_wr_i & hit[b]),
      .sel_i   (sel),
      .wdata_i (bus_wdata_i),
      .pend_o  (pend_w[b]),
      .ena_o   (ena_w[b]),
      .mode_o  (mode_w[b]),
      .cond_o  (cond_w[b]),
      .event_o (event_w[b]),
      .force_o (force_w[b]),
      .ack_o   (ack_w[b]),
      .rdval_o (rdval_w[b]),
      .irq_o   (irq_o[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (hit[b]) rd_mux |= rdval_w[b];
    end
  end

  assign rd_zero = bus_rd_i && (|hit) && (sel == RS_FORCE || sel == RS_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n)        bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NB = 4,
  parameter int W  = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NB-1:0]        irq_i,
  input logic [NB-1:0][W-1:0] pend_i,
  input logic [NB-1:0][W-1:0] ena_i,
  input logic [NB-1:0][W-1:0] mode_i,
  input logic [NB-1:0][W-1:0] cond_i,
  input logic [NB-1:0][W-1:0] event_i,
  input logic [NB-1:0][W-1:0] force_i,
  input logic [NB-1:0][W-1:0] ack_i,
  input logic                 rd_zero_i,
  input logic [W-1:0]         rdata_i
);
  for (genvar b = 0; b < NB; b++) begin : g_chk
    p_mask_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_i[b] == '0) |-> !irq_i[b]);

    p_ack_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ack_i[b] & mode_i[b] & ~event_i[b] & ~force_i[b]))
      |=> ((pend_i[b] & $past(ack_i[b] & mode_i[b] & ~event_i[b] & ~force_i[b])) == '0));

    p_level_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(~mode_i[b] & ~force_i[b]))
      |=> (((pend_i[b] ^ $past(cond_i[b])) & $past(~mode_i[b] & ~force_i[b])) == '0));

    p_force_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|force_i[b]) |=> ((pend_i[b] & $past(force_i[b])) == $past(force_i[b])));

    p_event_latches_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|(event_i[b] & mode_i[b]))
      |=> ((pend_i[b] & $past(event_i[b] & mode_i[b])) == $past(event_i[b] & mode_i[b])));
  end

  p_strobe_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_zero_i |=> (rdata_i == '0));
endmodule

bind bank_irq_ctrl irqc_checker #(.NB(NUM_BANKS), .W(SRC_PER_BANK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_i     (irq_o),
  .pend_i    (pend_w),
  .ena_i     (ena_w),
  .mode_i    (mode_w),
  .cond_i    (cond_w),
  .event_i   (event_w),
  .force_i   (force_w),
  .ack_i     (ack_w),
  .rd_zero_i (rd_zero),
  .rdata_i   (bus_rdata_o)
);

// File: tb/bank_irq_ctrl_tb.sv
`timescale 1ns/1ps
module bank_irq_ctrl_tb;
  localparam int NB = 4;
  localparam int W  = 32;
  localparam int AW = 8;
  localparam int SPAN = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB*W-1:0] src = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [NB-1:0] irq;

  bank_irq_ctrl #(.NUM_BANKS(NB), .SRC_PER_BANK(W), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  always #2.5 clk = ~clk;

  // Behavioural reference state
  logic [W-1:0] m_ena[NB], m_pol[NB], m_mode[NB], m_pend[NB], m_prev[NB], m_s1[NB], m_s2[NB];
  logic [W-1:0] m_rdata;
  bit           m_rd_pend = 0;
  int           edges = 0;
  int           n_cmp = 0, n_bad = 0;
  string        cur_req = "R1";
  bit           done = 0;

  always @(posedge clk) begin
    int bk, wi;
    logic [W-1:0] cnd, evt, fv, av;
    edges++;
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        m_ena[b] = '0; m_pol[b] = '1; m_mode[b] = '0; m_pend[b] = '0;
        m_prev[b] = '0; m_s1[b] = '0; m_s2[b] = '0;
      end
      m_rd_pend = 0;
    end else begin
      bk = -1; wi = 0;
      if (int'(bus_addr) < NB*SPAN) begin
        bk = int'(bus_addr) / SPAN;
        wi = (int'(bus_addr) % SPAN) / 4;
      end
      m_rd_pend = bus_rd;
      if (bus_rd) begin
        m_rdata = '0;
        if (bk >= 0) begin
          case (wi)
            0: m_rdata = m_pend[bk];
            1: m_rdata = m_ena[bk];
            4: m_rdata = m_pol[bk];
            5: m_rdata = m_mode[bk];
            default: m_rdata = '0;
          endcase
        end
      end
      for (int b = 0; b < NB; b++) begin
        cnd = (m_s2[b] & m_pol[b]) | (~m_s2[b] & ~m_pol[b]);
        evt = cnd & ~m_prev[b];
        fv  = (bus_wr && bk == b && wi == 2) ? bus_wdata : '0;
        av  = (bus_wr && bk == b && wi == 3) ? bus_wdata : '0;
        m_pend[b] = fv | (m_mode[b] & ((m_pend[b] & ~av) | evt)) | (~m_mode[b] & cnd);
        m_prev[b] = cnd;
        m_s2[b]   = m_s1[b];
        m_s1[b]   = src[b*W +: W];
        if (bus_wr && bk == b && wi == 1) m_ena[b]  = bus_wdata;
        if (bus_wr && bk == b && wi == 4) m_pol[b]  = bus_wdata;
        if (bus_wr && bk == b && wi == 5) m_mode[b] = bus_wdata;
      end
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    logic [NB-1:0] exp_irq;
    if (edges > 0 && !done) begin
      for (int b = 0; b < NB; b++) exp_irq[b] = |(m_pend[b] & m_ena[b]);
      n_cmp++;
      if (irq !== exp_irq) begin
        n_bad++;
        $display("FAIL %s (R3) irq actual %h expected %h at %0t", cur_req, irq, exp_irq, $time);
      end
      if (m_rd_pend) begin
        n_cmp++;
        if (bus_rdata !== m_rdata) begin
          n_bad++;
          $display("FAIL %s (R10) rdata actual %h expected %h at %0t", cur_req, bus_rdata, m_rdata, $time);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    if (edges > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", edges);
      finish_run();
    end
  end

  task automatic wr(input int a, input logic [W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values readable in every bank
    cur_req = "R1";
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < 6; i++) rd(b*SPAN + 4*i);

    // R2: out-of-window accesses; unaligned low bits ignored
    cur_req = "R2";
    rd(NB*SPAN); rd(8'hFC);
    wr(NB*SPAN, 32'hFFFF_FFFF);
    rd(1*SPAN + 4 + 2);
    rd(0);

    // R9 / R11: bank 0 bits 13..15 edge-triggered, rising edge latches
    cur_req = "R9";
    wr(8'h14, 32'h0000_E000);
    wr(8'h04, 32'hFFFF_FFFF);
    @(negedge clk); src[13] = 1'b1;
    @(negedge clk); src[13] = 1'b0;
    cur_req = "R11";
    idle(1); rd(8'h00); idle(3); rd(8'h00);

    // R5: zero bits ignored, one bits acknowledge
    cur_req = "R5";
    wr(8'h0C, 32'h0); rd(8'h00);
    wr(8'h0C, 32'h0000_2000); rd(8'h00);

    // R6: level mode mirrors input; acknowledge has no lasting effect
    cur_req = "R6";
    wr(SPAN + 4, 32'hFFFF_FFFF);
    @(negedge clk); src[W + 3] = 1'b1;
    idle(5);
    wr(SPAN + 12, 32'h0000_0008); idle(3); rd(SPAN);
    src[W + 3] = 1'b0; idle(4); rd(SPAN);

    // R8: active-low level and falling-edge detection
    cur_req = "R8";
    wr(2*SPAN + 16, 32'hFFFF_FFFC);
    wr(2*SPAN + 20, 32'h0000_0002);
    wr(2*SPAN + 4, 32'h0000_0003);
    idle(4); rd(2*SPAN);
    wr(2*SPAN + 12, 32'h0000_0002); rd(2*SPAN);
    @(negedge clk); src[2*W] = 1'b1; src[2*W + 1] = 1'b1;
    idle(4); rd(2*SPAN);
    src[2*W + 1] = 1'b0; idle(4); rd(2*SPAN);

    // R4: masking keeps pending status
    cur_req = "R4";
    wr(2*SPAN + 4, 32'h0); idle(2); rd(2*SPAN);
    wr(2*SPAN + 4, 32'h0000_0002); idle(2);

    // R7 / R10: force, then read the strobe registers
    cur_req = "R7";
    wr(3*SPAN + 20, 32'h8000_0000);
    wr(3*SPAN + 4, 32'h8000_0001);
    wr(3*SPAN + 8, 32'h8000_0001); rd(3*SPAN);
    cur_req = "R10";
    rd(3*SPAN + 8); rd(3*SPAN + 12);
    wr(3*SPAN + 12, 32'h8000_0000); rd(3*SPAN);

    // R9 collision sweep: acknowledge vs. new edge on bank 0 bit 14
    cur_req = "R9";
    for (int d = 0; d < 6; d++) begin
      @(negedge clk); src[14] = 1'b1;
      idle(d);
      wr(8'h0C, 32'h0000_4000);
      idle(3); rd(8'h00);
      src[14] = 1'b0; idle(3);
      wr(8'h0C, 32'h0000_4000); rd(8'h00);
    end

    // R3: mixed random traffic
    cur_req = "R3";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      src = {$urandom, $urandom, $urandom, $urandom};
      bus_wr = 1'b0; bus_rd = 1'b0;
      case ($urandom % 4)
        0: begin bus_wr = 1'b1; bus_addr = AW'(($urandom % 26) * 4); bus_wdata = $urandom; end
        1: begin bus_rd = 1'b1; bus_addr = AW'(($urandom % 26) * 4); end
        default: ;
      endcase
    end
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
    idle(4);
    finish_run();
  end
endmodule